// File: doc/BRIEF.md
# E1 Spare and International Bit Receive Capture

This block sits behind an E1 receive framer and collects the overhead bits of timeslot 0 across a CRC4 multiframe. The framer presents one timeslot-0 bit per strobe, together with that bit's position inside the timeslot and the number of the frame inside the multiframe. The block steers each bit of interest into one of eight 8-bit shift lanes: the international bit of the even (alignment) frames, the international bit of the odd (non-alignment) frames, the remote alarm bit, and the five spare bits Sa4 through Sa8.

When the last timeslot-0 bit of frame 15 is accepted, all eight lanes are copied at once into holding registers that the host reads. At the same moment a sticky multiframe flag is raised. The host then has a whole multiframe (2 ms) to read the holding registers before the next boundary overwrites them, and it clears the flag by writing a one to the clear input. The spare-bit holding registers carry, for example, the synchronization status message, which a host decodes by comparing successive sub-multiframes.

Top module: `e1sa_rx_capture`

## Requirements
- R1: After reset every holding register output and the multiframe flag read zero.
- R2: In frames with an even number (frame_num bit 0 = 0) the bit at bit_idx 0 (timeslot-0 bit 1) shifts into the even-frame international lane, so frame 0's bit lands in bit 7 and frame 14's bit in bit 0 of rx_si_even.
- R3: In odd frames the bit at bit_idx 0 shifts into rx_si_odd, frame 1's bit in bit 7 and frame 15's bit in bit 0.
- R4: In odd frames the bit at bit_idx 2 (timeslot-0 bit 3) shifts into rx_ra with the same first-received-in-MSB ordering.
- R5: In odd frames the bits at bit_idx 3 to 7 shift into the spare lanes Sa4 to Sa8; rx_sa[7:0] holds Sa4, rx_sa[15:8] Sa5, up to rx_sa[39:32] for Sa8, first-received bit in the MSB of each byte.
- R6: The holding registers change only at a multiframe boundary, which is an accepted bit (bit_valid = 1) with frame_num = 15 and bit_idx = 7; the new values, including that last bit, appear on the clock edge that accepts it.
- R7: Bits with bit_valid = 0, the alignment-frame bits at bit_idx 1 to 7, and the odd-frame bit at bit_idx 1 affect no register and no flag.
- R8: mf_flag rises on the edge of each boundary and stays high until clr_flag = 1 is sampled; a clear sampled on the same edge as a boundary leaves the flag high.
- R9: Holding registers keep the previous multiframe's values while the next multiframe is being shifted in, up to its boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Strobe: bit_data is a timeslot-0 bit this cycle |
| bit_data | input | 1 | Received timeslot-0 bit |
| bit_idx | input | 3 | Position in timeslot 0, 0 = first received (bit 1) |
| frame_num | input | 4 | Frame number inside the CRC4 multiframe, 0..15 |
| clr_flag | input | 1 | Write-one-to-clear for mf_flag |
| rx_si_even | output | 8 | International bits of alignment frames |
| rx_si_odd | output | 8 | International bits of non-alignment frames |
| rx_ra | output | 8 | Remote alarm bits |
| rx_sa | output | 40 | Spare bits Sa4 (low byte) to Sa8 (high byte) |
| mf_flag | output | 1 | Sticky multiframe boundary flag |

## Verification
Whole multiframes are sent with eight distinct byte values for the eight lanes while the unused timeslot-0 positions carry all zeros in one pass and all ones in another, so a bit steered to the wrong lane or a leaking filler bit shows up as a wrong byte. An all-zero and an all-ones multiframe pin down stuck routing, and one multiframe interleaves invalid strobes carrying inverted data to show that unstrobed bits are dropped. Half-way through a multiframe the outputs are compared with the previous one to separate loading at the boundary from loading earlier, and directed cases cover an unstrobed boundary position, the flag's stickiness and a clear that collides with a boundary.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

  // Lane numbering shared by the decoder, the top level and the checker.
  localparam int LANE_SI_EVEN = 0;
  localparam int LANE_SI_ODD  = 1;
  localparam int LANE_RA      = 2;
  localparam int LANE_SA_BASE = 3;
  localparam int LANE_NONE    = -1;

  // Timeslot-0 position (0 = first bit) of the remote alarm bit in odd frames.
  localparam int POS_SI = 0;
  localparam int POS_RA = 2;

  // Which lane a timeslot-0 bit belongs to, or LANE_NONE.
  function automatic int lane_of(input logic odd_frame, input int pos);
    if (!odd_frame)
      return (pos == POS_SI) ? LANE_SI_EVEN : LANE_NONE;
    if (pos == POS_SI)
      return LANE_SI_ODD;
    if (pos == POS_RA)
      return LANE_RA;
    if (pos >= LANE_SA_BASE)
      return pos;
    return LANE_NONE;
  endfunction

  // Multiframe boundary: last bit of the last frame.
  function automatic logic is_last_bit(input int frame, input int pos,
                                       input int frames, input int bits);
    return (frame == frames - 1) && (pos == bits - 1);
  endfunction

endpackage

// File: rtl/e1sa_slot_decode.sv
module e1sa_slot_decode
  import e1sa_pkg::*;
#(
  parameter int FRAMES_PER_MF = 16,
  parameter int TS_BITS       = 8,
  localparam int FRAME_W      = $clog2(FRAMES_PER_MF),
  localparam int IDX_W        = $clog2(TS_BITS),
  localparam int NUM_LANES    = TS_BITS
) (
  input  logic                 bit_valid,
  input  logic [IDX_W-1:0]     bit_idx,
  input  logic [FRAME_W-1:0]   frame_num,
  output logic [NUM_LANES-1:0] lane_sel,
  output logic                 mf_boundary
);

  logic odd_frame;
  assign odd_frame = frame_num[0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_sel
    assign lane_sel[g] = bit_valid && (lane_of(odd_frame, int'(bit_idx)) == g);
  end

  assign mf_boundary = bit_valid &&
                       is_last_bit(int'(frame_num), int'(bit_idx), FRAMES_PER_MF, TS_BITS);

endmodule

// File: rtl/e1sa_lane.sv
module e1sa_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              load,
  output logic [WORD_W-1:0] hold_q
);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_next;

  // Oldest bit drifts toward the MSB as later bits arrive.
  always_comb begin
    shift_next = shift_q;
    if (shift_en)
      shift_next = {shift_q[WORD_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      shift_q <= shift_next;
      if (load)
        hold_q <= shift_next;
    end
  end

endmodule

// File: rtl/e1sa_flag.sv
module e1sa_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);

  logic clr_eff;
  assign clr_eff = clr_req && !set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_evt)
      flag_q <= 1'b1;
    else if (clr_eff)
      flag_q <= 1'b0;
  end

endmodule

// File: rtl/e1sa_rx_capture.sv
module e1sa_rx_capture
  import e1sa_pkg::*;
#(
  parameter int FRAMES_PER_MF = 16,
  parameter int TS_BITS       = 8,
  localparam int FRAME_W      = $clog2(FRAMES_PER_MF),
  localparam int IDX_W        = $clog2(TS_BITS),
  localparam int WORD_W       = FRAMES_PER_MF / 2,
  localparam int NUM_SA       = TS_BITS - LANE_SA_BASE,
  localparam int SA_W         = NUM_SA * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_valid,
  input  logic               bit_data,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               clr_flag,
  output logic [WORD_W-1:0]  rx_si_even,
  output logic [WORD_W-1:0]  rx_si_odd,
  output logic [WORD_W-1:0]  rx_ra,
  output logic [SA_W-1:0]    rx_sa,
  output logic               mf_flag
);

  localparam int NUM_LANES = TS_BITS;

  logic [NUM_LANES-1:0] lane_sel;
  logic                 mf_boundary;
  logic [WORD_W-1:0]    hold [NUM_LANES];

  e1sa_slot_decode #(
    .FRAMES_PER_MF(FRAMES_PER_MF),
    .TS_BITS      (TS_BITS)
  ) i_decode (
    .bit_valid  (bit_valid),
    .bit_idx    (bit_idx),
    .frame_num  (frame_num),
    .lane_sel   (lane_sel),
    .mf_boundary(mf_boundary)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    e1sa_lane #(.WORD_W(WORD_W)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(lane_sel[g]),
      .bit_in  (bit_data),
      .load    (mf_boundary),
      .hold_q  (hold[g])
    );
  end

  e1sa_flag i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(mf_boundary),
    .clr_req(clr_flag),
    .flag_q (mf_flag)
  );

  assign rx_si_even = hold[LANE_SI_EVEN];
  assign rx_si_odd  = hold[LANE_SI_ODD];
  assign rx_ra      = hold[LANE_RA];

  for (genvar s = 0; s < NUM_SA; s++) begin : g_sa
    assign rx_sa[s*WORD_W +: WORD_W] = hold[LANE_SA_BASE + s];
  end

endmodule

// File: rtl/e1sa_rx_capture_chk.sv
module e1sa_rx_capture_chk #(
  parameter int FRAMES_PER_MF = 16,
  parameter int TS_BITS       = 8,
  localparam int FRAME_W      = $clog2(FRAMES_PER_MF),
  localparam int IDX_W        = $clog2(TS_BITS),
  localparam int WORD_W       = FRAMES_PER_MF / 2,
  localparam int SA_W         = (TS_BITS - 3) * WORD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_valid,
  input logic [IDX_W-1:0]   bit_idx,
  input logic [FRAME_W-1:0] frame_num,
  input logic               clr_flag,
  input logic [TS_BITS-1:0] lane_sel,
  input logic               mf_boundary,
  input logic [WORD_W-1:0]  rx_si_even,
  input logic [WORD_W-1:0]  rx_si_odd,
  input logic [WORD_W-1:0]  rx_ra,
  input logic [SA_W-1:0]    rx_sa,
  input logic               mf_flag
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (mf_flag == 1'b0) && (rx_ra == '0)); // R1

  AST_EVEN_SI_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !frame_num[0] && bit_idx == 0) |-> (lane_sel == 1)); // R2

  AST_ODD_SI_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && frame_num[0] && bit_idx == 0) |-> (lane_sel == 2)); // R3

  AST_RA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && frame_num[0] && bit_idx == 2) |-> (lane_sel == 4)); // R4

  AST_SA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && frame_num[0] && bit_idx >= 3) |-> $onehot0(lane_sel) && lane_sel[bit_idx]); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_boundary |=> $stable(rx_si_even) && $stable(rx_si_odd) && $stable(rx_ra) && $stable(rx_sa)); // R6

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> (lane_sel == '0) && !mf_boundary); // R7

  AST_FILL_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_num[0] && bit_idx != 0) || (frame_num[0] && bit_idx == 1) |-> (lane_sel == '0)); // R7

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mf_boundary |=> mf_flag); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !mf_boundary) |=> !mf_flag); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_flag && !mf_boundary) |=> $stable(mf_flag)); // R8

endmodule

bind e1sa_rx_capture e1sa_rx_capture_chk #(
  .FRAMES_PER_MF(FRAMES_PER_MF),
  .TS_BITS      (TS_BITS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_valid  (bit_valid),
  .bit_idx    (bit_idx),
  .frame_num  (frame_num),
  .clr_flag   (clr_flag),
  .lane_sel   (lane_sel),
  .mf_boundary(mf_boundary),
  .rx_si_even (rx_si_even),
  .rx_si_odd  (rx_si_odd),
  .rx_ra      (rx_ra),
  .rx_sa      (rx_sa),
  .mf_flag    (mf_flag)
);

// File: tb/test_e1sa_rx_capture.sv
module test_e1sa_rx_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic [2:0]  bit_idx = '0;
  logic [3:0]  frame_num = '0;
  logic        clr_flag = 1'b0;
  logic [7:0]  rx_si_even, rx_si_odd, rx_ra;
  logic [39:0] rx_sa;
  logic        mf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  e1sa_rx_capture i_e1sa_rx_capture (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_idx(bit_idx), .frame_num(frame_num), .clr_flag(clr_flag),
    .rx_si_even(rx_si_even), .rx_si_odd(rx_si_odd), .rx_ra(rx_ra),
    .rx_sa(rx_sa), .mf_flag(mf_flag)
  );

  // {si_even, si_odd, ra, sa4, sa5, sa6, sa7, sa8, filler}
  localparam logic [71:0] VEC [4] = '{
    72'hB4_3C_01_80_55_AA_F0_0F_00,
    72'h12_34_56_78_9A_BC_DE_F1_FF,
    72'h00_00_00_00_00_00_00_00_FF,
    72'hFF_FF_FF_FF_FF_FF_FF_FF_00
  };

  // Bit carried on the line for frame f, timeslot position i.
  function automatic logic line_bit(logic [71:0] v, int f, int i);
    int pos = 7 - f / 2;
    if (f % 2 == 0) return (i == 0) ? v[64 + pos] : v[i];
    if (i == 0) return v[56 + pos];
    if (i == 1) return v[1];
    if (i == 2) return v[48 + pos];
    return v[40 - 8 * (i - 3) + pos];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [71:0] v);
    check({req, "/R2 si_even"}, rx_si_even, v[71:64]);
    check({req, "/R3 si_odd"},  rx_si_odd,  v[63:56]);
    check({req, "/R4 ra"},      rx_ra,      v[55:48]);
    for (int s = 0; s < 5; s++)
      check({req, "/R5 sa"}, rx_sa[8*s +: 8], v[47 - 8*s -: 8]);
  endtask

  task automatic beat(logic v, int f, int i, logic d, logic c);
    @(negedge clk);
    bit_valid = v; frame_num = 4'(f); bit_idx = 3'(i); bit_data = d; clr_flag = c;
  endtask

  task automatic idle();
    @(negedge clk);
    bit_valid = 1'b0; clr_flag = 1'b0;
  endtask

  task automatic send_frames(logic [71:0] v, int f_lo, int f_hi, bit gap, bit clr_last);
    for (int f = f_lo; f <= f_hi; f++)
      for (int i = 0; i < 8; i++) begin
        if (gap) beat(1'b0, f, i, ~line_bit(v, f, i), 1'b0);
        beat(1'b1, f, i, line_bit(v, f, i), clr_last && f == 15 && i == 7);
      end
    idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag", {7'd0, mf_flag}, 8'h00);
    check_all("R1", 72'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      send_frames(VEC[k], 0, 7, k == 2, 1'b0);
      if (k > 0) check_all("R9 mid", VEC[k-1]);
      else       check_all("R9 mid", 72'h0);
      send_frames(VEC[k], 8, 14, k == 2, 1'b0);
      for (int i = 0; i < 7; i++) beat(1'b1, 15, i, line_bit(VEC[k], 15, i), 1'b0);
      idle();
      if (k > 0) check_all("R6 before last", VEC[k-1]);
      beat(1'b1, 15, 7, line_bit(VEC[k], 15, 7), 1'b0);
      idle();
      check_all("R6 boundary", VEC[k]);
      check("R8 set", {7'd0, mf_flag}, 8'h01);
      beat(1'b0, 0, 0, 1'b0, 1'b1);
      idle();
      check("R8 clear", {7'd0, mf_flag}, 8'h00);
    end

    // Unstrobed bit at the boundary position: no load, no flag.
    beat(1'b0, 15, 7, 1'b1, 1'b0);
    idle();
    check("R7 flag", {7'd0, mf_flag}, 8'h00);
    check_all("R7 hold", VEC[3]);

    // Clear on the same edge as a boundary: boundary wins.
    send_frames(VEC[0], 0, 15, 1'b0, 1'b1);
    check("R8 collide", {7'd0, mf_flag}, 8'h01);
    check_all("R8 collide", VEC[0]);
    repeat (5) idle();
    check("R8 sticky", {7'd0, mf_flag}, 8'h01);

    // Reset mid-run returns to zero.
    rst_n = 1'b0;
    idle();
    check("R1 rerun flag", {7'd0, mf_flag}, 8'h00);
    check_all("R1 rerun", 72'h0);
    rst_n = 1'b1;
    idle();
    finish_run();
  end

endmodule